// File: doc/BRIEF.md
# Sticky Error Status Register Slice with Interrupt Summary

This block is a small register slice on a byte-wide microprocessor bus. Single-cycle error pulses arrive from three transmit channels, three receive channels and a phase-locked-loop detector. The loop detector pulses when its phase error hits the upper or the lower limit. Each pulse sets its own bit in a status byte. The bit stays set until software reads that byte, and the read returns the contents and then empties the register.

Two interrupt request outputs summarise the status byte. The transmit request covers the transmit bits. The receive request covers the receive bits and also the loop bit. Each of the three source groups has an enable bit in a control byte. A cleared enable keeps its group out of the interrupt, but its status bits still latch.

A shadow byte records the data of the most recent bus write to any address, including addresses that decode to nothing. Diagnostics can read it back to confirm that the data bus works.

Top module: `err_sticky_regs`

## Requirements
- R1: The status byte reads at address 0x3C. Bits 2:0 hold transmit channels 1–3, bits 5:3 hold receive channels 1–3, bit 6 holds the loop error, and bit 7 always reads 0.
- R2: A status bit set by a pulse stays set until a read of address 0x3C is accepted.
- R3: A read is accepted when `cs`=1 and `we`=0 at a clock edge. `rdata` presents the addressed register after that edge. A read of 0x3C returns the contents held before the edge and clears every bit at that edge.
- R4: A pulse that arrives on the same edge as a clearing read leaves its bit set after the clear. The data returned by that read does not include the pulse.
- R5: `irq_tx` is 1 exactly when a transmit status bit is set and control bit 0 is 1.
- R6: `irq_rx` is 1 exactly when a receive status bit is set with control bit 1 at 1, or the loop status bit is set with control bit 2 at 1.
- R7: The control byte is read/write at address 0x3D. Bit 0 enables transmit, bit 1 enables receive, bit 2 enables the loop, and bits 7:3 read 0.
- R8: Every accepted write, to any address, stores `wdata` in the shadow byte. A read of address 0x3B returns the shadow byte.
- R9: A write to 0x3C does not change the status byte.
- R10: Synchronous active-high `rst` clears the status, control and shadow bytes, so both interrupt outputs read 0.
- R11: A read of an address with no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Bus select |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tx_pulse | input | 3 | Transmit channel error pulses |
| rx_pulse | input | 3 | Receive channel error pulses |
| pll_pulse | input | 1 | Loop phase-limit error pulse |
| irq_tx | output | 1 | Transmit error interrupt request |
| irq_rx | output | 1 | Receive and loop error interrupt request |

## Verification
The hardest case to reach from the ports is a clearing read that lands on the same edge as a new error pulse. To create it, the stimulus raises a receive pulse in the same cycle as the status read. The scoreboard then expects the read to return only the older transmit bit, and the next read to return only the receive bit. The enable gating is checked in a second step. All three sources latch while every enable is 0. The enables are then opened one at a time, and each interrupt output is checked without clearing the status byte.

// File: rtl/err_sticky_pkg.sv
package err_sticky_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned EN_W   = 3;
   localparam int unsigned EN_TX  = 0;
   localparam int unsigned EN_RX  = 1;
   localparam int unsigned EN_PLL = 2;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_STATUS,
      SEL_SHADOW,
      SEL_CTRL
   } rd_sel_e;
endpackage

// File: rtl/err_bus_decode.sv
module err_bus_decode
   import err_sticky_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h3C,
   parameter logic [ADDR_W-1:0] SHADOW_ADDR = 'h3B,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h3D
) (
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output rd_sel_e           rd_sel,
   output logic              rd_accept,
   output logic              rd_status,
   output logic              wr_any,
   output logic              wr_ctrl
);
   always_comb begin
      rd_accept = cs && !we;
      wr_any    = cs && we;
      wr_ctrl   = wr_any && (addr == CTRL_ADDR);
      rd_sel    = SEL_NONE;
      if (addr == STATUS_ADDR)      rd_sel = SEL_STATUS;
      else if (addr == SHADOW_ADDR) rd_sel = SEL_SHADOW;
      else if (addr == CTRL_ADDR)   rd_sel = SEL_CTRL;
      rd_status = rd_accept && (rd_sel == SEL_STATUS);
   end
endmodule

// File: rtl/err_sticky_bank.sv
module err_sticky_bank #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] status_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)           status_o[i] <= 1'b0;
         else if (set_i[i]) status_o[i] <= 1'b1;
         else if (clr_i)    status_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/err_irq_combine.sv
module err_irq_combine #(
   parameter int unsigned N_TX      = 3,
   parameter int unsigned N_RX      = 3,
   parameter bit          PLL_ON_RX = 1'b1,
   localparam int unsigned N_SRC    = N_TX + N_RX + 1
) (
   input  logic [N_SRC-1:0] status,
   input  logic             en_tx,
   input  logic             en_rx,
   input  logic             en_pll,
   output logic             irq_tx,
   output logic             irq_rx
);
   logic any_tx, any_rx, pll_req;

   always_comb begin
      any_tx  = en_tx && (|status[N_TX-1:0]);
      any_rx  = en_rx && (|status[N_TX+N_RX-1:N_TX]);
      pll_req = en_pll && status[N_SRC-1];
   end

   if (PLL_ON_RX) begin : g_pll_rx
      assign irq_tx = any_tx;
      assign irq_rx = any_rx || pll_req;
   end else begin : g_pll_tx
      assign irq_tx = any_tx || pll_req;
      assign irq_rx = any_rx;
   end
endmodule

// File: rtl/err_sticky_regs.sv
module err_sticky_regs
   import err_sticky_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned N_TX        = 3,
   parameter int unsigned N_RX        = 3,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h3C,
   parameter logic [ADDR_W-1:0] SHADOW_ADDR = 'h3B,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h3D,
   parameter bit          PLL_ON_RX   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [N_TX-1:0]   tx_pulse,
   input  logic [N_RX-1:0]   rx_pulse,
   input  logic              pll_pulse,
   output logic              irq_tx,
   output logic              irq_rx
);
   localparam int unsigned N_SRC = N_TX + N_RX + 1;

   if (N_SRC >= DATA_W + 1) begin : g_bad_width
      $error("status sources exceed data width");
   end
   if (DATA_W < EN_W) begin : g_bad_ctrl
      $error("data width too narrow for control byte");
   end
   if (STATUS_ADDR == SHADOW_ADDR || STATUS_ADDR == CTRL_ADDR ||
       SHADOW_ADDR == CTRL_ADDR) begin : g_bad_addr
      $error("register addresses must be distinct");
   end

   rd_sel_e            rd_sel;
   logic               rd_accept, rd_status, wr_any, wr_ctrl;
   logic [N_SRC-1:0]   status_q;
   logic [EN_W-1:0]    ctrl_q;
   logic [DATA_W-1:0]  shadow_q;
   logic [DATA_W-1:0]  rd_mux;

   err_bus_decode #(
      .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR),
      .SHADOW_ADDR(SHADOW_ADDR), .CTRL_ADDR(CTRL_ADDR)
   ) u_dec (
      .cs(cs), .we(we), .addr(addr), .rd_sel(rd_sel),
      .rd_accept(rd_accept), .rd_status(rd_status),
      .wr_any(wr_any), .wr_ctrl(wr_ctrl)
   );

   err_sticky_bank #(.N(N_SRC)) u_bank (
      .clk(clk), .rst(rst),
      .set_i({pll_pulse, rx_pulse, tx_pulse}),
      .clr_i(rd_status),
      .status_o(status_q)
   );

   err_irq_combine #(.N_TX(N_TX), .N_RX(N_RX), .PLL_ON_RX(PLL_ON_RX)) u_irq (
      .status(status_q),
      .en_tx(ctrl_q[EN_TX]), .en_rx(ctrl_q[EN_RX]), .en_pll(ctrl_q[EN_PLL]),
      .irq_tx(irq_tx), .irq_rx(irq_rx)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q   <= '0;
         shadow_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q   <= wdata[EN_W-1:0];
         if (wr_any)  shadow_q <= wdata;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (rd_sel)
         SEL_STATUS: rd_mux[N_SRC-1:0] = status_q;
         SEL_SHADOW: rd_mux            = shadow_q;
         SEL_CTRL:   rd_mux[EN_W-1:0]  = ctrl_q;
         default:    rd_mux            = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)            rdata <= '0;
      else if (rd_accept) rdata <= rd_mux;
   end
endmodule

// File: rtl/err_sticky_regs_chk.sv
module err_sticky_regs_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned N_TX   = 3,
   parameter int unsigned N_RX   = 3,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 'h3C,
   localparam int unsigned N_SRC = N_TX + N_RX + 1
) (
   input logic              clk,
   input logic              rst,
   input logic              cs,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic [N_TX-1:0]   tx_pulse,
   input logic [N_RX-1:0]   rx_pulse,
   input logic              pll_pulse,
   input logic              irq_tx,
   input logic              irq_rx,
   input logic [N_SRC-1:0]  status_q,
   input logic [2:0]        ctrl_q,
   input logic [DATA_W-1:0] shadow_q
);
   logic             rd_stat;
   logic [N_SRC-1:0] pulses;
   logic [DATA_W-1:0] status_wide;
   always_comb begin
      rd_stat = cs && !we && (addr == STATUS_ADDR);
      pulses  = {pll_pulse, rx_pulse, tx_pulse};
      status_wide = '0;
      status_wide[N_SRC-1:0] = status_q;
   end

   assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
      !rd_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

   assert_read_data_R3: assert property (@(posedge clk) disable iff (rst)
      rd_stat |=> (rdata == $past(status_wide)));

   assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_stat && (pulses == '0)) |=> (status_q == '0));

   assert_collision_R4: assert property (@(posedge clk) disable iff (rst)
      rd_stat |=> (status_q == $past(pulses)));

   assert_tx_gate_R5: assert property (@(posedge clk) disable iff (rst)
      !ctrl_q[0] |-> !irq_tx);

   assert_rx_gate_R6: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_q[1] && !ctrl_q[2]) |-> !irq_rx);

   assert_shadow_capture_R8: assert property (@(posedge clk) disable iff (rst)
      (cs && we) |=> (shadow_q == $past(wdata)));

   assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !(cs && we) |=> $stable(shadow_q));

   assert_reset_R10: assert property (@(posedge clk)
      rst |=> (status_q == '0 && ctrl_q == '0 && shadow_q == '0));
endmodule

bind err_sticky_regs err_sticky_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_TX(N_TX), .N_RX(N_RX),
   .STATUS_ADDR(STATUS_ADDR)
) u_chk (
   .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
   .rdata(rdata), .tx_pulse(tx_pulse), .rx_pulse(rx_pulse),
   .pll_pulse(pll_pulse), .irq_tx(irq_tx), .irq_rx(irq_rx),
   .status_q(status_q), .ctrl_q(ctrl_q), .shadow_q(shadow_q)
);

// File: tb/err_sticky_regs_bench.sv
module err_sticky_regs_bench;
   localparam int CLK_P = 10;
   localparam logic [7:0] A_STAT = 8'h3C;
   localparam logic [7:0] A_SHAD = 8'h3B;
   localparam logic [7:0] A_CTRL = 8'h3D;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs = 1'b0, we = 1'b0;
   logic [7:0] addr = '0, wdata = '0, rdata;
   logic [2:0] tx_pulse = '0, rx_pulse = '0;
   logic       pll_pulse = 1'b0;
   logic       irq_tx, irq_rx;

   int n_vec = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_q = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   err_sticky_regs u_err_sticky_regs (
      .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tx_pulse(tx_pulse), .rx_pulse(rx_pulse),
      .pll_pulse(pll_pulse), .irq_tx(irq_tx), .irq_rx(irq_rx)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // driver: pushes the expected read value, monitor pops it
   task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      cs = 1'b1; we = 1'b0; addr = a;
      @(negedge clk);
      cs = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      cs = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; we = 1'b0;
   endtask

   task automatic pulse(input logic [2:0] t, input logic [2:0] r, input logic p);
      tx_pulse = t; rx_pulse = r; pll_pulse = p;
      @(negedge clk);
      tx_pulse = '0; rx_pulse = '0; pll_pulse = 1'b0;
   endtask

   task automatic irqs(input logic et, input logic er, input string tag);
      chk({6'd0, irq_tx, irq_rx}, {6'd0, et, er}, tag);
   endtask

   // monitor
   always @(posedge clk) rd_q <= cs && !we && !rst;
   always @(negedge clk) begin
      if (rd_q) begin
         if (exp_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL R3 unexpected read: actual=%02h expected=none", rdata);
         end else begin
            chk(rdata, exp_q.pop_front(), tag_q.pop_front());
         end
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R10 reset state
      irqs(1'b0, 1'b0, "R10 irq after reset");
      do_read(A_STAT, 8'h00, "R10 status after reset");
      do_read(A_SHAD, 8'h00, "R10 shadow after reset");
      do_read(A_CTRL, 8'h00, "R10 ctrl after reset");
      // R7 control byte
      do_write(A_CTRL, 8'hFF);
      do_read(A_CTRL, 8'h07, "R7 ctrl upper bits read 0");
      do_read(A_SHAD, 8'hFF, "R8 shadow holds ctrl write");
      // R1 R5 transmit channel 2
      pulse(3'b010, 3'b000, 1'b0);
      irqs(1'b1, 1'b0, "R5 tx ch2 raises irq_tx");
      do_read(A_STAT, 8'h02, "R1 tx ch2 bit1");
      irqs(1'b0, 1'b0, "R3 irq drops after clear");
      do_read(A_STAT, 8'h00, "R3 status cleared by read");
      // R1 R6 receive channel 3 plus loop
      pulse(3'b000, 3'b100, 1'b1);
      irqs(1'b0, 1'b1, "R6 rx ch3 and loop raise irq_rx");
      do_read(A_STAT, 8'h60, "R1 rx ch3 bit5 loop bit6");
      // R2 sticky over idle cycles
      pulse(3'b001, 3'b000, 1'b0);
      repeat (5) @(negedge clk);
      irqs(1'b1, 1'b0, "R2 irq_tx held");
      do_read(A_STAT, 8'h01, "R2 tx ch1 held");
      // R4 collision of pulse and clearing read
      pulse(3'b100, 3'b000, 1'b0);
      rx_pulse = 3'b001;
      do_read(A_STAT, 8'h04, "R4 read excludes same-edge pulse");
      rx_pulse = '0;
      irqs(1'b0, 1'b1, "R4 irq_rx survives clear");
      do_read(A_STAT, 8'h08, "R4 same-edge pulse kept");
      // R5 R6 enable gating
      do_write(A_CTRL, 8'h00);
      pulse(3'b001, 3'b001, 1'b1);
      irqs(1'b0, 1'b0, "R5 R6 all enables off");
      do_write(A_CTRL, 8'h01);
      irqs(1'b1, 1'b0, "R5 tx enable only");
      do_write(A_CTRL, 8'h04);
      irqs(1'b0, 1'b1, "R6 loop enable only");
      do_write(A_CTRL, 8'h02);
      irqs(1'b0, 1'b1, "R6 rx enable only");
      do_read(A_STAT, 8'h49, "R1 latched while gated");
      pulse(3'b000, 3'b000, 1'b1);
      irqs(1'b0, 1'b0, "R6 loop masked by its enable");
      do_write(A_CTRL, 8'h04);
      irqs(1'b0, 1'b1, "R6 loop drives irq_rx");
      do_read(A_STAT, 8'h40, "R1 loop bit6");
      // R8 R11 unmapped write and read
      do_write(8'hA5, 8'h5A);
      do_read(A_SHAD, 8'h5A, "R8 shadow from unmapped write");
      do_read(8'hA5, 8'h00, "R11 unmapped read");
      // R9 write to status is ignored
      do_write(A_STAT, 8'h7F);
      irqs(1'b0, 1'b0, "R9 write to status no irq");
      do_read(A_STAT, 8'h00, "R9 status unchanged by write");
      do_read(A_SHAD, 8'h7F, "R8 shadow from status write");
      do_read(A_CTRL, 8'h04, "R7 ctrl kept");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_vec++; n_bad++;
         $display("FAIL R3 missing reads: actual=%0d expected=0", exp_q.size());
      end
      finish_run();
   end
endmodule